// File: doc/BRIEF.md
# Temperature Threshold Alert Controller

This block watches a stream of temperature samples and raises an alert when readings cross programmable limits. Each sample is a 16-bit word whose upper 12 bits carry a two's-complement temperature (0.0625 °C per step). The lower 4 bits are don't-care. A sample is compared with a high limit and a low limit. A small counter demands that a chosen number of back-to-back samples meet the armed condition before anything changes, so noise near a limit does not make the output chatter.

Two behaviours are selectable. In comparator mode the output acts as a thermostat with hysteresis: it turns on above the high limit and off below the low limit. In interrupt mode each accepted crossing raises a pulse that software acknowledges with any register read or with entry into sleep. The armed condition then swaps between the high and the low limit. A general reset pulse drops the block back to comparator mode and clears all alert state. Output polarity is programmable. A status bit records which limit was last crossed.

The sample input has a valid/ready pair. Ready is always high, so the block never applies back-pressure: every cycle with valid high delivers one sample. Configuration and the pulse inputs are plain levels that take effect on the next clock edge.

Top module: `temp_alert_ctrl`

## Requirements
- R1: Comparisons are signed and use only bits [15:4] of the sample and of both limits. Bits [3:0] are ignored. The high condition is T >= high and the low condition is T <= low.
- R2: The fault field F (2 bits) sets N = F + 1 consecutive qualifying samples before a condition is accepted.
- R3: A valid sample that fails the armed condition restarts the consecutive count from zero.
- R4: In comparator mode the alert turns on after N samples at or above the high limit and turns off only after N samples at or below the low limit. Reads, sleep pulses and cycles without a valid sample do not change it.
- R5: In interrupt mode an accepted crossing makes the alert active. It stays active until a read pulse or a sleep pulse clears it. Samples are not counted while it is active.
- R6: In interrupt mode the armed condition alternates: after a high crossing only N samples at or below the low limit raise the next alert, and after a low crossing only the high limit does.
- R7: The alert pin equals the polarity bit while the alert is active and its inverse otherwise. Polarity 0 gives an active-low output and 1 gives active-high.
- R8: The status bit reads the inverse of polarity while the block is idle or after a low crossing. It reads equal to polarity after a high crossing, in either mode, and read pulses do not change it.
- R9: A general reset pulse clears the alert state and the count and forces comparator mode. Comparator mode holds until the interrupt-mode input changes value again.
- R10: A change of the interrupt-mode input clears the consecutive count and any pending interrupt alert. A sample presented in that cycle is not counted.
- R11: After reset the alert is idle (pin and status both equal the inverse of polarity) and sample ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample word valid |
| smp_ready | output | 1 | Sample accepted (always high) |
| smp_temp | input | 16 | Sample word, temperature in [15:4] |
| thr_high | input | 16 | High limit word, value in [15:4] |
| thr_low | input | 16 | Low limit word, value in [15:4] |
| cfg_intr_mode | input | 1 | 1 selects interrupt mode, 0 comparator |
| cfg_pol | input | 1 | Output polarity, 1 = active high |
| cfg_faults | input | 2 | Consecutive-sample field F, N = F + 1 |
| rd_pulse | input | 1 | Any register read occurred |
| sleep_pulse | input | 1 | Sleep entry occurred |
| gcall_rst | input | 1 | General reset command |
| alert_pin | output | 1 | Alert output level |
| alert_stat | output | 1 | Alert status bit |

## Verification
The hardest case to reach is the interrupt-mode case where samples arrive while an alert is still unacknowledged. The count must stay frozen, and the next crossing must still require a full run of N samples after the read. The directed sequence raises an interrupt with N = 2, sends one low sample while it is pending, acknowledges it, and then shows that one further low sample is not enough. The random phase mixes mode flips, general resets, fault-field changes and reads near both limits. This catches orderings such as a read that coincides with a completing run.

// File: rtl/tac_pkg.sv
package tac_pkg;
  typedef enum logic {ARM_HIGH = 1'b0, ARM_LOW = 1'b1} arm_t;

  function automatic logic drive_level(input logic active, input logic pol);
    return active ? pol : ~pol;
  endfunction
endpackage

// File: rtl/tac_compare.sv
module tac_compare
  import tac_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int FRAC_W = 4
) (
  input  logic [WORD_W-1:0] temp_w,
  input  logic [WORD_W-1:0] high_w,
  input  logic [WORD_W-1:0] low_w,
  input  arm_t              armed,
  output logic              hit
);
  localparam int VAL_W = WORD_W - FRAC_W;

  logic signed [VAL_W-1:0] t_v, h_v, l_v;

  always_comb begin
    t_v = $signed(temp_w[WORD_W-1:FRAC_W]);
    h_v = $signed(high_w[WORD_W-1:FRAC_W]);
    l_v = $signed(low_w[WORD_W-1:FRAC_W]);
    hit = (armed == ARM_LOW) ? (t_v <= l_v) : (t_v >= h_v);
  end
endmodule

// File: rtl/tac_fault_filter.sv
module tac_fault_filter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             hit,
  input  logic [CNT_W-1:0] limit,
  output logic             evt,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign evt   = step && hit && (cnt_q >= limit);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (step) begin
      if (!hit || evt) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tac_mode_track.sv
module tac_mode_track (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_im,
  input  logic gcall,
  output logic im_q,
  output logic mode_chg
);
  logic prev_q;

  assign mode_chg = (cfg_im != prev_q) && !gcall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      im_q   <= 1'b0;
    end else begin
      prev_q <= cfg_im;
      if (gcall)         im_q <= 1'b0;
      else if (mode_chg) im_q <= cfg_im;
    end
  end
endmodule

// File: rtl/tac_alert_state.sv
module tac_alert_state (
  input  logic clk,
  input  logic rst_n,
  input  logic im,
  input  logic evt,
  input  logic irq_clr,
  input  logic flush,
  input  logic gcall,
  output logic over_q,
  output logic irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      over_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (gcall)    over_q <= 1'b0;
      else if (evt) over_q <= ~over_q;

      if (flush || irq_clr) irq_q <= 1'b0;
      else if (evt && im)   irq_q <= 1'b1;
    end
  end
endmodule

// File: rtl/temp_alert_ctrl.sv
module temp_alert_ctrl
  import tac_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int FRAC_W = 4,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [WORD_W-1:0] smp_temp,
  input  logic [WORD_W-1:0] thr_high,
  input  logic [WORD_W-1:0] thr_low,
  input  logic              cfg_intr_mode,
  input  logic              cfg_pol,
  input  logic [CNT_W-1:0]  cfg_faults,
  input  logic              rd_pulse,
  input  logic              sleep_pulse,
  input  logic              gcall_rst,
  output logic              alert_pin,
  output logic              alert_stat
);
  logic             im_q, mode_chg, flush, step, hit, evt, irq_clr;
  logic             over_q, irq_q;
  logic [CNT_W-1:0] flt_cnt;
  arm_t             armed;

  assign smp_ready = 1'b1;
  assign flush     = gcall_rst | mode_chg;
  assign step      = smp_valid && !(im_q && irq_q) && !flush;
  assign irq_clr   = im_q && (rd_pulse || sleep_pulse);
  assign armed     = over_q ? ARM_LOW : ARM_HIGH;

  tac_mode_track u_mode (
    .clk(clk), .rst_n(rst_n), .cfg_im(cfg_intr_mode), .gcall(gcall_rst),
    .im_q(im_q), .mode_chg(mode_chg)
  );

  tac_compare #(.WORD_W(WORD_W), .FRAC_W(FRAC_W)) u_cmp (
    .temp_w(smp_temp), .high_w(thr_high), .low_w(thr_low),
    .armed(armed), .hit(hit)
  );

  tac_fault_filter #(.CNT_W(CNT_W)) u_flt (
    .clk(clk), .rst_n(rst_n), .clr(flush), .step(step), .hit(hit),
    .limit(cfg_faults), .evt(evt), .cnt_o(flt_cnt)
  );

  tac_alert_state u_st (
    .clk(clk), .rst_n(rst_n), .im(im_q), .evt(evt), .irq_clr(irq_clr),
    .flush(flush), .gcall(gcall_rst), .over_q(over_q), .irq_q(irq_q)
  );

  assign alert_pin  = drive_level(im_q ? irq_q : over_q, cfg_pol);
  assign alert_stat = drive_level(over_q, cfg_pol);
endmodule

// File: rtl/tac_alert_chk.sv
module tac_alert_chk #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             rd_pulse,
  input logic             sleep_pulse,
  input logic             gcall_rst,
  input logic             cfg_intr_mode,
  input logic             cfg_pol,
  input logic             alert_pin,
  input logic             im_q,
  input logic             over_q,
  input logic             irq_q,
  input logic [CNT_W-1:0] flt_cnt
);
  // R9
  gcall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gcall_rst |=> (!im_q && !over_q && !irq_q));

  // R5
  pending_freezes_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (im_q && irq_q) |-> (flt_cnt == '0));

  // R5
  ack_clears_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (im_q && cfg_intr_mode && (rd_pulse || sleep_pulse) && !gcall_rst)
      |=> (alert_pin != cfg_pol));

  // R4
  only_samples_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !gcall_rst) |=> $stable(over_q));

  // R10
  pending_only_in_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> im_q);
endmodule

bind temp_alert_ctrl tac_alert_chk #(.CNT_W(CNT_W)) u_alert_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .rd_pulse(rd_pulse),
  .sleep_pulse(sleep_pulse), .gcall_rst(gcall_rst),
  .cfg_intr_mode(cfg_intr_mode), .cfg_pol(cfg_pol), .alert_pin(alert_pin),
  .im_q(im_q), .over_q(over_q), .irq_q(irq_q), .flt_cnt(flt_cnt)
);

// File: tb/temp_alert_ctrl_test.sv
`timescale 1ns/1ps
module temp_alert_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_temp = '0;
  logic [15:0] thr_high = 16'h5000;
  logic [15:0] thr_low  = 16'h4B00;
  logic        cfg_intr_mode = 1'b0;
  logic        cfg_pol = 1'b0;
  logic [1:0]  cfg_faults = 2'd0;
  logic        rd_pulse = 1'b0, sleep_pulse = 1'b0, gcall_rst = 1'b0;
  logic        alert_pin, alert_stat;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  // bench model state
  bit m_im = 0, m_prev = 0, m_over = 0, m_irq = 0;
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  temp_alert_ctrl uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_temp(smp_temp), .thr_high(thr_high), .thr_low(thr_low),
    .cfg_intr_mode(cfg_intr_mode), .cfg_pol(cfg_pol), .cfg_faults(cfg_faults),
    .rd_pulse(rd_pulse), .sleep_pulse(sleep_pulse), .gcall_rst(gcall_rst),
    .alert_pin(alert_pin), .alert_stat(alert_stat)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic signed [11:0] t, h, l;
    bit hit, evt, clr;
    t = $signed(smp_temp[15:4]); h = $signed(thr_high[15:4]); l = $signed(thr_low[15:4]);
    evt = 0;
    if (gcall_rst) begin
      m_im = 0; m_over = 0; m_irq = 0; m_cnt = 0;
    end else if (cfg_intr_mode != m_prev) begin
      m_im = cfg_intr_mode; m_cnt = 0; m_irq = 0;
    end else begin
      clr = m_im && (rd_pulse || sleep_pulse);
      if (smp_valid && !(m_im && m_irq)) begin
        hit = m_over ? (t <= l) : (t >= h);
        if (!hit) m_cnt = 0;
        else if (m_cnt >= int'(cfg_faults)) begin evt = 1; m_cnt = 0; end
        else m_cnt++;
      end
      if (evt) begin m_over = !m_over; if (m_im) m_irq = 1; end
      if (clr) m_irq = 0;
    end
    m_prev = cfg_intr_mode;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic samp(input logic [15:0] w);
    smp_valid = 1; smp_temp = w; tick(); smp_valid = 0;
  endtask
  task automatic rd();    rd_pulse = 1;    tick(); rd_pulse = 0;    endtask
  task automatic slp();   sleep_pulse = 1; tick(); sleep_pulse = 0; endtask
  task automatic gcall(); gcall_rst = 1;   tick(); gcall_rst = 0;   endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2917));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    chk("R11 pin idle", alert_pin, 1'b1);
    chk("R11 stat idle", alert_stat, 1'b1);
    chk("R11 ready", smp_ready, 1'b1);

    // R2: N=3
    cfg_faults = 2'd2;
    samp(16'h5000); samp(16'h5000);
    chk("R2 two of three", alert_pin, 1'b1);
    samp(16'h5000);
    chk("R2 third sample", alert_pin, 1'b0);
    chk("R8 high crossing", alert_stat, 1'b0);

    // R3: a failing sample restarts the count
    samp(16'h4B00); samp(16'h4B00); samp(16'h4C00); samp(16'h4B00); samp(16'h4B00);
    chk("R3 restart", alert_pin, 1'b0);
    samp(16'h4B00);
    chk("R4 deassert", alert_pin, 1'b1);
    chk("R8 low crossing", alert_stat, 1'b1);

    // R1: signed compare and ignored nibble
    cfg_faults = 2'd0; thr_high = 16'hFFF0; thr_low = 16'hFE00;
    samp(16'h0000);
    chk("R1 signed high", alert_pin, 1'b0);
    samp(16'h8000);
    chk("R1 signed low", alert_pin, 1'b1);
    thr_high = 16'h5000; thr_low = 16'h4B00;
    samp(16'h4FFF);
    chk("R1 below limit", alert_pin, 1'b1);
    samp(16'h500F);
    chk("R1 equal with nibble", alert_pin, 1'b0);

    // R4: reads and sleep do not touch comparator state
    rd(); slp(); samp(16'h4C00);
    chk("R4 read sleep ignored", alert_pin, 1'b0);

    // R9 general reset
    gcall();
    chk("R9 pin cleared", alert_pin, 1'b1);
    chk("R9 stat cleared", alert_stat, 1'b1);

    // R5 / R6 interrupt mode, N=1
    cfg_intr_mode = 1; tick();
    samp(16'h5000);
    chk("R5 irq raised", alert_pin, 1'b0);
    samp(16'h5000);
    chk("R5 irq held", alert_pin, 1'b0);
    rd();
    chk("R5 read clears", alert_pin, 1'b1);
    chk("R8 stat kept after read", alert_stat, 1'b0);
    samp(16'h5000);
    chk("R6 high not armed", alert_pin, 1'b1);
    samp(16'h4B00);
    chk("R6 low raises", alert_pin, 1'b0);
    chk("R8 stat after low", alert_stat, 1'b1);
    slp();
    chk("R5 sleep clears", alert_pin, 1'b1);

    // R5 counting suspended while pending, N=2
    cfg_faults = 2'd1;
    samp(16'h5000); samp(16'h5000);
    chk("R5 N=2 raise", alert_pin, 1'b0);
    samp(16'h4B00); rd(); samp(16'h4B00);
    chk("R5 count frozen while pending", alert_pin, 1'b1);
    samp(16'h4B00);
    chk("R6 low after full run", alert_pin, 1'b0);

    // R9 forces comparator mode while input stays 1
    gcall();
    chk("R9 irq cleared", alert_pin, 1'b1);
    cfg_faults = 2'd0;
    samp(16'h5000); rd();
    chk("R9 comparator after reset", alert_pin, 1'b0);

    // R10 mode change clears count
    cfg_faults = 2'd1;
    samp(16'h4B00);
    cfg_intr_mode = 0; tick();
    samp(16'h4B00);
    chk("R10 count cleared", alert_pin, 1'b0);
    samp(16'h4B00);
    chk("R10 full run after change", alert_pin, 1'b1);

    // R7 polarity
    cfg_pol = 1; #1;
    chk("R7 active high idle", alert_pin, 1'b0);
    chk("R8 stat inverted", alert_stat, 1'b0);
    @(negedge clk);

    // random phase against the bench model
    for (int i = 0; i < 4000; i++) begin
      smp_valid   = ($urandom_range(0, 9) < 7);
      smp_temp    = {12'h4A0 + 12'($urandom_range(0, 112)), 4'($urandom)};
      rd_pulse    = ($urandom_range(0, 9) == 0);
      sleep_pulse = ($urandom_range(0, 31) == 0);
      gcall_rst   = ($urandom_range(0, 99) == 0);
      if ($urandom_range(0, 39) == 0) cfg_intr_mode = ~cfg_intr_mode;
      if ($urandom_range(0, 19) == 0) cfg_pol = ~cfg_pol;
      if ($urandom_range(0, 19) == 0) cfg_faults = 2'($urandom);
      tick();
      chk("R7 random pin", alert_pin, (m_im ? m_irq : m_over) ? cfg_pol : !cfg_pol);
      chk("R8 random stat", alert_stat, m_over ? cfg_pol : !cfg_pol);
    end
    done = 1;
    summary();
    $finish;
  end
endmodule